// File: doc/BRIEF.md
# Dual-Law SPI Serial Clock Divider

This block turns a fast module clock into the timing strobes a serial peripheral interface shift engine needs to place its clock edges. It offers two divide laws, picked by a single select input. The linear law divides the module clock by 2*(N+1), where N is an 8-bit value. The exponent law divides the module clock by 2^M, where M is a 4-bit value. Use the exponent law for ratios above 512.

The output is a pair of one-cycle enables, emitted once per SCK half-period: a leading-edge tick and a trailing-edge tick, always in alternation. The shift engine toggles SCK on the leading tick and samples on the trailing tick, which gives a 50% duty cycle.

The divider only runs while the burst-active input is high. While that input is low, the count and the phase are held at zero, so every burst starts from the same point. The three divider settings come from an external register decode. They must stay constant during a burst.

Top module: `spi_clkdiv_dual`

## Requirements
- R1: While rst_n is low, or while run_i is low, both tick outputs are 0. They are still 0 on the cycle after run_i was sampled low.
- R2: With law_sel_i = 1 (linear law), a tick is output after every (lin_n_i + 1)-th consecutive clock edge at which run_i is sampled high. It is visible right after that edge.
- R3: With law_sel_i = 0 (exponent law) and exp_m_i = M >= 2, a tick is output after every 2^(M-1)-th consecutive run edge.
- R4: With law_sel_i = 0, exp_m_i = 0 and exp_m_i = 1 both give a tick after every run edge, which means SCK = module clock / 2.
- R5: Within a burst, the ticks alternate. The first tick is a leading tick (lead_tick_o), the next a trailing tick (trail_tick_o), and so on.
- R6: lead_tick_o and trail_tick_o are never high in the same cycle.
- R7: Dropping run_i clears the count and the phase. After a restart, the first tick is again a leading tick, exactly one half-period of run edges later.
- R8: The input of the law that is not selected has no effect. Changing lin_n_i while the exponent law is selected does not alter the tick pattern.
- R9: The extreme settings divide fully. lin_n_i = 255 gives a half-period of 256 edges (module clock / 512). exp_m_i = 15 gives a half-period of 16384 edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Module clock |
| rst_n | input | 1 | Active-low synchronous reset |
| run_i | input | 1 | Burst active; low holds the divider at its start point |
| law_sel_i | input | 1 | Divide law select: 1 = linear, 0 = exponent |
| lin_n_i | input | LIN_W (8) | Linear divisor N; the SCK period is 2*(N+1) module clocks |
| exp_m_i | input | EXP_W (4) | Exponent M; the SCK period is 2^M module clocks (M = 0 is treated as 1) |
| lead_tick_o | output | 1 | One-cycle enable for the SCK leading edge |
| trail_tick_o | output | 1 | One-cycle enable for the SCK trailing (sample) edge |

## Verification
Both ticks are registered. A tick is therefore due in the cycle after the H-th edge at which run_i is sampled high, where H is the half-period in edges. The outputs fall back to zero in the cycle after the first edge at which run_i is sampled low.

The reference model advances one step on each rising edge, using the inputs as held at that edge. Inputs change 2 ns after the edge, and the outputs are compared at the falling edge. Each comparison therefore sees exactly the registered result of the edge just before it.

The extreme half-periods, the restart and the unused-field stimulus are all compared against the model on every cycle.

// File: rtl/spi_clkdiv_pkg.sv
package spi_clkdiv_pkg;
   typedef enum logic {
      LAW_EXP = 1'b0,
      LAW_LIN = 1'b1
   } div_law_e;

   function automatic int half_w(input int lin_w, input int exp_w);
      int ew;
      ew = (1 << exp_w) - 1;
      return (lin_w + 1 > ew) ? lin_w + 1 : ew;
   endfunction
endpackage

// File: rtl/spi_clkdiv_law.sv
module spi_clkdiv_law
   import spi_clkdiv_pkg::*;
#(
   parameter int LIN_W = 8,
   parameter int EXP_W = 4,
   parameter int HW    = half_w(LIN_W, EXP_W)
) (
   input  logic             law_sel_i,
   input  logic [LIN_W-1:0] lin_n_i,
   input  logic [EXP_W-1:0] exp_m_i,
   output logic [HW-1:0]    last_o
);
   localparam int NEXP = 1 << EXP_W;

   logic [HW-1:0] exp_tab [NEXP];

   // Terminal count per exponent: half-period 2^(M-1) edges, M<2 gives 1
   for (genvar e = 0; e < NEXP; e++) begin : g_exp
      localparam int SH = (e < 2) ? 0 : e - 1;
      localparam logic [63:0] V64 = (64'd1 << SH) - 64'd1;
      assign exp_tab[e] = V64[HW-1:0];
   end

   always_comb begin
      if (div_law_e'(law_sel_i) == LAW_LIN)
         last_o = {{(HW-LIN_W){1'b0}}, lin_n_i};
      else
         last_o = exp_tab[exp_m_i];
   end
endmodule

// File: rtl/spi_clkdiv_count.sv
module spi_clkdiv_count #(
   parameter int HW = 15
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          run_i,
   input  logic [HW-1:0] last_i,
   output logic          lead_o,
   output logic          trail_o
);
   logic [HW-1:0] cnt;
   logic          phase;
   logic          seen_lead;

   always_ff @(posedge clk) begin
      if (!rst_n || !run_i) begin
         cnt     <= '0;
         phase   <= 1'b0;
         lead_o  <= 1'b0;
         trail_o <= 1'b0;
      end else if (cnt == last_i) begin
         cnt     <= '0;
         phase   <= ~phase;
         lead_o  <= ~phase;
         trail_o <= phase;
      end else begin
         cnt     <= cnt + 1'b1;
         lead_o  <= 1'b0;
         trail_o <= 1'b0;
      end
   end

   // Tracks which tick was last observed at the outputs
   always_ff @(posedge clk) begin
      if (!rst_n || !run_i) seen_lead <= 1'b0;
      else if (lead_o)      seen_lead <= 1'b1;
      else if (trail_o)     seen_lead <= 1'b0;
   end

   AST_ONE_KIND: assert property (@(posedge clk) disable iff (!rst_n)
      !(lead_o && trail_o)); // R6
   AST_ALTERNATE_LEAD: assert property (@(posedge clk) disable iff (!rst_n)
      lead_o |-> !seen_lead); // R5
   AST_ALTERNATE_TRAIL: assert property (@(posedge clk) disable iff (!rst_n)
      trail_o |-> seen_lead); // R5
   AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      !run_i |=> (!lead_o && !trail_o)); // R1
   AST_DIV2: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rst_n) && $past(run_i) && $past(last_i) == '0) |-> (lead_o || trail_o)); // R4
endmodule

// File: rtl/spi_clkdiv_dual.sv
module spi_clkdiv_dual
   import spi_clkdiv_pkg::*;
#(
   parameter int LIN_W = 8,
   parameter int EXP_W = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run_i,
   input  logic             law_sel_i,
   input  logic [LIN_W-1:0] lin_n_i,
   input  logic [EXP_W-1:0] exp_m_i,
   output logic             lead_tick_o,
   output logic             trail_tick_o
);
   localparam int HW = half_w(LIN_W, EXP_W);

   if (LIN_W < 1 || LIN_W > 30) begin : g_bad_lin
      $error("spi_clkdiv_dual: LIN_W out of range");
   end
   if (EXP_W < 1 || EXP_W > 5) begin : g_bad_exp
      $error("spi_clkdiv_dual: EXP_W out of range");
   end

   logic [HW-1:0] last;

   spi_clkdiv_law #(.LIN_W(LIN_W), .EXP_W(EXP_W), .HW(HW)) u_law (
      .law_sel_i (law_sel_i),
      .lin_n_i   (lin_n_i),
      .exp_m_i   (exp_m_i),
      .last_o    (last)
   );

   spi_clkdiv_count #(.HW(HW)) u_count (
      .clk     (clk),
      .rst_n   (rst_n),
      .run_i   (run_i),
      .last_i  (last),
      .lead_o  (lead_tick_o),
      .trail_o (trail_tick_o)
   );
endmodule

// File: tb/spi_clkdiv_dual_test.sv
module spi_clkdiv_dual_test;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       run = 1'b0;
   logic       sel = 1'b0;
   logic [7:0] lin_n = '0;
   logic [3:0] exp_m = '0;
   logic       lead, trail;

   int    checks = 0;
   int    errors = 0;
   int    cycles = 0;
   string cur_req = "R1";

   int k = 0;
   int ph = 0;
   logic exp_lead = 1'b0, exp_trail = 1'b0;

   always #5 clk = ~clk;

   spi_clkdiv_dual uut (
      .clk(clk), .rst_n(rst_n), .run_i(run), .law_sel_i(sel),
      .lin_n_i(lin_n), .exp_m_i(exp_m),
      .lead_tick_o(lead), .trail_tick_o(trail)
   );

   function automatic int half_period();
      if (sel) return int'(lin_n) + 1;
      if (exp_m < 2) return 1;
      return 1 << (int'(exp_m) - 1);
   endfunction

   // Behavioural reference: one step per rising edge
   always @(posedge clk) begin
      cycles++;
      if (!rst_n || !run) begin
         k = 0; ph = 0; exp_lead = 1'b0; exp_trail = 1'b0;
      end else begin
         k++;
         if (k % half_period() == 0) begin
            exp_lead = (ph == 0); exp_trail = (ph == 1); ph = 1 - ph;
         end else begin
            exp_lead = 1'b0; exp_trail = 1'b0;
         end
      end
   end

   always @(negedge clk) begin
      checks++;
      if (lead !== exp_lead || trail !== exp_trail) begin
         errors++;
         $display("FAIL %s: lead/trail=%b%b expected %b%b at cycle %0d",
                  cur_req, lead, trail, exp_lead, exp_trail, cycles);
      end
      checks++;
      if (lead === 1'b1 && trail === 1'b1) begin
         errors++;
         $display("FAIL R6: lead/trail=11 expected not both at cycle %0d", cycles);
      end
   end

   task automatic step(input int n);
      for (int i = 0; i < n; i++) begin
         @(posedge clk); #2;
      end
   endtask

   task automatic burst(input string req, input logic s, input logic [7:0] n,
                        input logic [3:0] m, input int len);
      cur_req = req;
      sel = s; lin_n = n; exp_m = m;
      step(1);
      run = 1'b1;
      step(len);
      run = 1'b0;
      step(3);
   endtask

   initial begin
      step(4);                               // R1 reset state
      rst_n = 1'b1;
      step(4);                               // R1 idle
      burst("R2", 1'b1, 8'd3, 4'd0, 40);     // R2 R5 linear N=3
      burst("R2", 1'b1, 8'd0, 4'd9, 12);     // R2 linear N=0
      burst("R3", 1'b0, 8'd7, 4'd3, 40);     // R3 exponent M=3
      burst("R3", 1'b0, 8'd7, 4'd5, 70);     // R3 exponent M=5
      burst("R4", 1'b0, 8'd1, 4'd0, 10);     // R4 M=0
      burst("R4", 1'b0, 8'd1, 4'd1, 10);     // R4 M=1
      // R7: stop mid half-period, then restart
      cur_req = "R7";
      sel = 1'b1; lin_n = 8'd4; exp_m = 4'd0;
      step(1); run = 1'b1; step(7);
      run = 1'b0; step(1);
      run = 1'b1; step(23);
      run = 1'b0; step(3);
      // R8: unused linear field changes every cycle under exponent law
      cur_req = "R8";
      sel = 1'b0; exp_m = 4'd2;
      step(1); run = 1'b1;
      for (int i = 0; i < 30; i++) begin
         lin_n = 8'(i * 37);
         step(1);
      end
      run = 1'b0; step(3);
      burst("R9", 1'b1, 8'd255, 4'd0, 1100); // R9 linear maximum
      burst("R9", 1'b0, 8'd0, 4'd15, 33000); // R9 exponent maximum
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      wait (cycles >= 150000);
      errors++;
      $display("FAIL watchdog: cycles=%0d expected completion", cycles);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule